// File: doc/BRIEF.md
# Sequential Sign-Magnitude Multiplier

This block multiplies two sign-magnitude words of 36 bits (one sign bit above a 35-bit magnitude). It works by shifting and adding, one step per clock. One operand arrives as the multiplicand. The other is loaded into a multiplier-quotient register. The 70-bit magnitude product is split across two result words. The accumulator word holds the upper 35 bits and the multiplier-quotient word holds the lower 35 bits. Both words carry the same product sign.

A start strobe samples both operands and a rounding select. When rounding is selected, the upper half is incremented if the most significant bit of the lower half is set. A zero multiplicand skips the shift-and-add loop entirely. The result registers hold their value from the done pulse until the next accepted start.

Top module: `sm_multiplier`

## Requirements
- R1: After reset, accOut and mqOut are all zeros and busy and done are low.
- R2: For magnitudes A (mcandIn[34:0]) and B (mqIn[34:0]), the 70-bit product P=A*B appears with accOut[34:0]=P[69:35] and mqOut[34:0]=P[34:0] when no rounding applies.
- R3: When mcandIn[34:0] is zero, no iterations run: mqOut[34:0] and accOut[34:0] are zero, and done is high in the cycle after the second rising edge, counting the start edge as the first.
- R4: With a nonzero multiplicand, exactly 35 iterations run, one per clock. done is high in the cycle after the 37th rising edge, counting the start edge as the first.
- R5: Bit 35 of both accOut and mqOut equals mcandIn[35] XOR mqIn[35] as sampled at start. This also holds for a zero product.
- R6: If roundSel was high at start and P[34] is 1, accOut[34:0] is P[69:35]+1. mqOut is unchanged by rounding.
- R7: done is a single-cycle pulse. busy is high from the cycle after an accepted start until the done cycle, and it is low during done.
- R8: A start while busy is ignored. The running result and its timing are unaffected.
- R9: accOut and mqOut hold their values from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply (accepted when not busy) |
| roundSel | input | 1 | Select the rounding variant, sampled with start |
| mcandIn | input | 36 | Multiplicand, bit 35 sign, bits 34:0 magnitude |
| mqIn | input | 36 | Multiplier, bit 35 sign, bits 34:0 magnitude |
| accOut | output | 36 | Product upper half, bit 35 product sign |
| mqOut | output | 36 | Product lower half, bit 35 product sign |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The assertions assume that start is synchronous and that the operands and roundSel are stable at the edge where start is sampled. Nothing is assumed about the operands while busy, because they are only captured at acceptance. The stimulus changes inputs only on the falling edge. It deliberately pulses start, with different operands, in the middle of a run, so that the rule of ignoring start while busy is exercised. The operand mix covers zero and maximum magnitudes, every sign combination, and cases with the rounding bit both set and clear.

// File: rtl/sm_mul_pkg.sv
package sm_mul_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mulCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mulState_t;
endpackage

// File: rtl/sm_mul_ctrl.sv
module sm_mul_ctrl
  import sm_mul_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    mcandZero,
  output mulCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = $clog2(MAG_W + 1);

  mulState_t state, stateNext;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    ctl.load   = (state == ST_IDLE) && start;
    ctl.step   = (state == ST_RUN);
    ctl.finish = (state == ST_FIN);
    stateNext  = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = mcandZero ? ST_FIN : ST_RUN;
      ST_RUN:  if (iterCnt == CNT_W'(1)) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctl.finish;
      if (ctl.load)      iterCnt <= CNT_W'(MAG_W);
      else if (ctl.step) iterCnt <= iterCnt - CNT_W'(1);
    end
  end

  assign busy = (state != ST_IDLE);

  // R7: done lasts one cycle and never overlaps busy
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: a start during the loop does not reload the iteration count
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) && start && (iterCnt > CNT_W'(1)) |=> iterCnt == $past(iterCnt) - CNT_W'(1));
endmodule

// File: rtl/sm_mul_dp.sv
module sm_mul_dp
  import sm_mul_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mulCtl_t          ctl,
  input  logic             roundSel,
  input  logic [MAG_W:0]   mcandIn,
  input  logic [MAG_W:0]   mqIn,
  output logic             mcandZero,
  output logic [MAG_W:0]   accOut,
  output logic [MAG_W:0]   mqOut
);
  logic [MAG_W-1:0] accMag, mqMag, mcandMag;
  logic             accSign, mqSign, prodNeg, roundReg;
  logic [MAG_W:0]   partSum;

  assign mcandZero = (mcandIn[MAG_W-1:0] == '0);
  assign partSum   = {1'b0, accMag} + {1'b0, (mqMag[0] ? mcandMag : '0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accMag   <= '0;
      mqMag    <= '0;
      mcandMag <= '0;
      accSign  <= 1'b0;
      mqSign   <= 1'b0;
      prodNeg  <= 1'b0;
      roundReg <= 1'b0;
    end else if (ctl.load) begin
      accMag   <= '0;
      mqMag    <= mcandZero ? '0 : mqIn[MAG_W-1:0];
      mcandMag <= mcandIn[MAG_W-1:0];
      accSign  <= 1'b0;
      mqSign   <= 1'b0;
      prodNeg  <= mcandIn[MAG_W] ^ mqIn[MAG_W];
      roundReg <= roundSel;
    end else if (ctl.step) begin
      accMag <= partSum[MAG_W:1];
      mqMag  <= {partSum[0], mqMag[MAG_W-1:1]};
    end else if (ctl.finish) begin
      if (roundReg && mqMag[MAG_W-1]) accMag <= accMag + MAG_W'(1);
      accSign <= prodNeg;
      mqSign  <= prodNeg;
    end
  end

  assign accOut = {accSign, accMag};
  assign mqOut  = {mqSign, mqMag};

  // R3: a zero multiplicand leaves the low half cleared after loading
  assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load && mcandZero |=> mqMag == '0);

  // R6: without rounding, the finishing step leaves both magnitudes alone
  assert_noround_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish && !roundReg |=> $stable(accMag) && $stable(mqMag));
endmodule

// File: rtl/sm_multiplier.sv
module sm_multiplier
  import sm_mul_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             roundSel,
  input  logic [MAG_W:0]   mcandIn,
  input  logic [MAG_W:0]   mqIn,
  output logic [MAG_W:0]   accOut,
  output logic [MAG_W:0]   mqOut,
  output logic             busy,
  output logic             done
);
  mulCtl_t ctl;
  logic    mcandZero;

  sm_mul_ctrl #(.MAG_W(MAG_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mcandZero(mcandZero),
    .ctl(ctl), .busy(busy), .done(done)
  );

  sm_mul_dp #(.MAG_W(MAG_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .roundSel(roundSel),
    .mcandIn(mcandIn), .mqIn(mqIn), .mcandZero(mcandZero),
    .accOut(accOut), .mqOut(mqOut)
  );
endmodule

// File: tb/sm_multiplier_tb_top.sv
`timescale 1ns/1ps
module sm_multiplier_tb_top;
  localparam int MAG_W = 35;
  localparam logic [34:0] MAXM = {35{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic roundSel = 1'b0;
  logic [35:0] mcandIn = '0;
  logic [35:0] mqIn = '0;
  logic [35:0] accOut, mqOut;
  logic busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curTag = "R2";

  // reference model state
  int rem = 0;
  logic busyExp = 1'b0, doneExp = 1'b0;
  logic [35:0] expAcc = '0, expMq = '0, pendAcc = '0, pendMq = '0;

  always #2 clk = ~clk;

  sm_multiplier #(.MAG_W(MAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .roundSel(roundSel),
    .mcandIn(mcandIn), .mqIn(mqIn), .accOut(accOut), .mqOut(mqOut),
    .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      rem = 0; busyExp = 0; doneExp = 0; expAcc = '0; expMq = '0;
    end else begin
      doneExp = 0;
      if (busyExp) begin
        rem--;
        if (rem == 0) begin
          busyExp = 0; doneExp = 1; expAcc = pendAcc; expMq = pendMq;
        end
      end else if (start) begin
        logic [69:0] prod;
        logic [34:0] hi;
        logic neg;
        prod = 70'(mcandIn[34:0]) * 70'(mqIn[34:0]);
        hi = prod[69:35];
        if (roundSel && prod[34]) hi = hi + 35'd1;
        neg = mcandIn[35] ^ mqIn[35];
        pendAcc = {neg, hi};
        pendMq = {neg, prod[34:0]};
        rem = (mcandIn[34:0] == '0) ? 1 : 36;
        busyExp = 1;
      end
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check({curTag, "/R4 done"}, {35'd0, done}, {35'd0, doneExp});
      check("R7 busy", {35'd0, busy}, {35'd0, busyExp});
      if (!busyExp) begin
        check({curTag, "/R9 acc"}, accOut, expAcc);
        check({curTag, "/R9 mq"}, mqOut, expMq);
      end
    end
  end

  task automatic runOp(input string tag, input logic [35:0] a, input logic [35:0] b,
                       input logic rnd);
    @(negedge clk);
    curTag = tag;
    mcandIn = a; mqIn = b; roundSel = rnd; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mcandIn = '0; mqIn = '0; roundSel = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc", accOut, '0);
    check("R1 mq", mqOut, '0);
    check("R1 flags", {34'd0, busy, done}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    runOp("R2", {1'b0, 35'd12345}, {1'b0, 35'd6789}, 1'b0);
    runOp("R2", {1'b0, MAXM}, {1'b0, MAXM}, 1'b0);
    runOp("R5", {1'b1, 35'd7}, {1'b0, 35'h4_0000_0003}, 1'b0);
    runOp("R5", {1'b1, 35'h1234_5678}, {1'b1, 35'h7_0F0F_0F0F}, 1'b0);
    runOp("R5", {1'b0, 35'd99}, {1'b1, 35'd0}, 1'b0);
    runOp("R3", {1'b1, 35'd0}, {1'b0, 35'h5_5555_5555}, 1'b0);
    runOp("R3", {1'b0, 35'd0}, {1'b0, MAXM}, 1'b1);
    runOp("R6", {1'b0, 35'h4_0000_0000}, {1'b0, 35'd1}, 1'b1);
    runOp("R6", {1'b1, 35'd3}, {1'b0, 35'h4_0000_0000}, 1'b1);
    runOp("R6", {1'b0, MAXM}, {1'b0, MAXM}, 1'b1);
    runOp("R6", {1'b0, 35'h4_0000_0000}, {1'b0, 35'd1}, 1'b0);

    // R8: start pulsed mid-run with other operands must be ignored
    @(negedge clk);
    curTag = "R8";
    mcandIn = {1'b0, 35'd1000}; mqIn = {1'b0, 35'd3000}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    mcandIn = {1'b1, 35'd5}; mqIn = {1'b1, 35'd5}; roundSel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; roundSel = 1'b0;
    repeat (40) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule